// File: doc/BRIEF.md
# Banked Register Window Decoder

This block sits between a host bus and the register file of a peripheral that exposes a 16-byte I/O window. The lower fourteen bytes of the window are shared by several register banks, and a bank register that the block holds itself picks which bank they reach. For every host access the block looks at the byte address, the byte lane enables, the read and write strobes and a valid-cycle qualifier. It then raises a select for exactly one internal register slot, or for none. The registers behind those selects, and any bus-width adaptation, belong to other blocks.

The bank register sits in the top word of the window and is reachable from every bank. Its upper byte is a fixed identity value that software can probe for to find the window. Its low byte holds the bank number, with the unused bits reading as zero. The highest bank number is reserved for add-on logic outside the block. When that bank is active, accesses to the low half of the window drive an active-low external chip select and select no internal slot. Bank numbers between the last internal bank and the external bank decode to nothing.

Top module: `bank_window_decoder`

## Requirements
- R1: On reset the bank field becomes 0. A word read at byte address Eh (lanes 2 and 3 enabled) then returns 32'h3300_0000.
- R2: A valid write with lane 2 enabled and address bits A3:A2 = 3 loads the bank field from write data bits 18:16. Write data bits 23:19 are dropped, and those bits read back as 0 in the bank byte (rdata 23:16).
- R3: The identity byte at Fh (lane 3, rdata 31:24) always reads 33h, and writes to it have no effect on any state.
- R4: The bank register can be read and written in every bank value 0 to 7.
- R5: The bank register is reachable as a doubleword at Ch (lanes 1111), as a word at Eh (lanes 1100) or as a byte at Fh (lane 1000). Byte lane k of an access carries byte address 4*A3:A2 + k, and lanes that are not enabled read as 0.
- R6: For bank b below 4, a valid read or write selects reg_sel bit b*7+s. Here s is the word slot (byte address / 2, range 0 to 6) of the lowest enabled byte. At most one select is high at any time.
- R7: A write that enables lane 2 or lane 3 with A3:A2 = 3, such as a doubleword write at Ch, raises no slot select. When lane 2 is enabled it still updates the bank field.
- R8: With bank 7 selected, a valid read or write with A3 = 0 drives ext_cs_n low, and bank 7 raises no internal select.
- R9: ext_cs_n stays high whenever the valid qualifier is low, no strobe is active, A3 = 1, or the bank is not 7.
- R10: In banks 4, 5 and 6 no select is raised, ext_cs_n stays high, reads of bytes 0h to Dh return 0, and writes there leave the bank register unchanged.
- R11: With the valid qualifier low, no select is raised, rdata is 0 and writes do not change the bank field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| cyc_valid | input | 1 | Qualifies the current bus cycle |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| addr | input | 4 | Byte address A3..A0 within the window |
| byte_en | input | 4 | Byte lane enables of the 32-bit bus |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data from the bank register lanes |
| reg_sel | output | 28 | One select per internal register slot, index bank*7+slot |
| ext_cs_n | output | 1 | Active-low select for external registers in bank 7 |

## Verification
A corrupted bank field shows at once in two ways. The next access selects a slot in the wrong bank, and a read of Eh returns the wrong low byte in the same cycle. Both paths are combinational from the register, so an error written at one edge is visible during the very next access. A wrong lane mapping or a missing write suppression shows in the same cycle as a stray or missing select bit or as a non-zero lane. A bad write to the bank register shows one clock later when the bank register is read back.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

   localparam int unsigned DATA_W  = 32;
   localparam int unsigned ADDR_W  = 4;
   localparam int unsigned LANES   = DATA_W / 8;

   typedef struct packed {
      logic              valid;
      logic              rd;
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [LANES-1:0]  be;
   } bus_acc_t;

   // top dword of the window holds the bank register in lanes 2 and 3
   function automatic logic in_top_dword(input bus_acc_t a);
      return a.addr[3:2] == 2'b11;
   endfunction

endpackage

// File: rtl/bwd_bank_reg.sv
module bwd_bank_reg
   import bwd_pkg::*;
#(
   parameter int unsigned BANK_BITS  = 3,
   parameter int unsigned RESET_BANK = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  bus_acc_t             acc,
   input  logic [7:0]           lane2_byte,
   output logic [BANK_BITS-1:0] bank_q
);

   if (BANK_BITS < 1 || BANK_BITS > 8) begin : g_bad_bits
      $error("bwd_bank_reg: BANK_BITS must be 1..8");
   end
   if (RESET_BANK >= (1 << BANK_BITS)) begin : g_bad_reset
      $error("bwd_bank_reg: RESET_BANK out of range");
   end

   logic load;
   assign load = acc.valid && acc.wr && in_top_dword(acc) && acc.be[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= BANK_BITS'(RESET_BANK);
      else if (load) bank_q <= lane2_byte[BANK_BITS-1:0];
   end

   // R2 / R11: the bank field moves only after a qualified write to lane 2
   assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q != $past(bank_q)) |->
         $past(acc.valid && acc.wr && acc.addr[3:2] == 2'b11 && acc.be[2]));

   assert_bank_novalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc.valid |=> $stable(bank_q));

endmodule

// File: rtl/bwd_slot_decoder.sv
module bwd_slot_decoder
   import bwd_pkg::*;
#(
   parameter int unsigned BANK_BITS = 3,
   parameter int unsigned INT_BANKS = 4,
   parameter int unsigned SLOTS     = 7,
   parameter int unsigned EXT_BANK  = 7,
   localparam int unsigned SEL_W    = INT_BANKS * SLOTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  bus_acc_t             acc,
   input  logic [BANK_BITS-1:0] bank,
   output logic [SEL_W-1:0]     reg_sel,
   output logic                 ext_cs_n
);

   if (SLOTS < 1 || SLOTS > 7) begin : g_bad_slots
      $error("bwd_slot_decoder: SLOTS must be 1..7");
   end
   if (INT_BANKS < 1 || INT_BANKS > EXT_BANK) begin : g_bad_banks
      $error("bwd_slot_decoder: INT_BANKS must be 1..EXT_BANK");
   end
   if (EXT_BANK >= (1 << BANK_BITS)) begin : g_bad_ext
      $error("bwd_slot_decoder: EXT_BANK does not fit BANK_BITS");
   end

   logic       any_be;
   logic [1:0] low_lane;
   logic [2:0] slot;
   logic       active;
   logic       wr_suppress;
   logic       slot_ok;

   // lowest enabled byte lane picks the word slot
   always_comb begin
      low_lane = 2'd0;
      for (int k = LANES - 1; k >= 0; k--) begin
         if (acc.be[k]) low_lane = 2'(k);
      end
   end

   assign any_be      = |acc.be;
   assign slot        = {acc.addr[3:2], low_lane[1]};
   assign active      = acc.valid && (acc.rd || acc.wr) && any_be;
   assign slot_ok     = 32'(slot) < SLOTS;
   assign wr_suppress = acc.wr && in_top_dword(acc) && (acc.be[2] || acc.be[3]);

   for (genvar b = 0; b < INT_BANKS; b++) begin : g_bank
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         assign reg_sel[b*SLOTS + s] = active && slot_ok && !wr_suppress
                                       && (32'(bank) == b) && (32'(slot) == s);
      end
   end

   assign ext_cs_n = !(acc.valid && (acc.rd || acc.wr)
                       && (32'(bank) == EXT_BANK) && !acc.addr[3]);

   assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));

   assert_dword_nosel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.wr && acc.addr[3:2] == 2'b11 && acc.be[2]) |-> (reg_sel == '0));

   assert_ext_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cs_n |-> (reg_sel == '0));

   assert_ext_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cs_n |-> (acc.valid && !acc.addr[3]));

   assert_idle_nosel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc.valid |-> (reg_sel == '0 && ext_cs_n));

endmodule

// File: rtl/bwd_readback.sv
module bwd_readback
   import bwd_pkg::*;
#(
   parameter int unsigned BANK_BITS = 3,
   parameter logic [7:0]  SIGNATURE = 8'h33
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  bus_acc_t             acc,
   input  logic [BANK_BITS-1:0] bank,
   output logic [DATA_W-1:0]    rdata
);

   logic rd_top;
   assign rd_top = acc.valid && acc.rd && in_top_dword(acc);

   always_comb begin
      rdata = '0;
      if (rd_top) begin
         if (acc.be[2]) rdata[23:16] = 8'(bank);
         if (acc.be[3]) rdata[31:24] = SIGNATURE;
      end
   end

   assert_sig_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.valid && acc.rd && acc.addr[3:2] == 2'b11 && acc.be[3])
         |-> (rdata[31:24] == SIGNATURE));

   assert_low_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc.valid && acc.rd) |-> (rdata == '0));

endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
   import bwd_pkg::*;
#(
   parameter int unsigned BANK_BITS  = 3,
   parameter int unsigned INT_BANKS  = 4,
   parameter int unsigned SLOTS      = 7,
   parameter int unsigned EXT_BANK   = 7,
   parameter int unsigned RESET_BANK = 0,
   parameter logic [7:0]  SIGNATURE  = 8'h33,
   localparam int unsigned SEL_W     = INT_BANKS * SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_valid,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [3:0]        addr,
   input  logic [3:0]        byte_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [SEL_W-1:0]  reg_sel,
   output logic              ext_cs_n
);

   bus_acc_t             acc;
   logic [BANK_BITS-1:0] bank;

   assign acc = '{valid: cyc_valid, rd: rd_stb, wr: wr_stb, addr: addr, be: byte_en};

   bwd_bank_reg #(.BANK_BITS(BANK_BITS), .RESET_BANK(RESET_BANK)) u_bank (
      .clk(clk), .rst_n(rst_n), .acc(acc), .lane2_byte(wdata[23:16]), .bank_q(bank)
   );

   bwd_slot_decoder #(
      .BANK_BITS(BANK_BITS), .INT_BANKS(INT_BANKS), .SLOTS(SLOTS), .EXT_BANK(EXT_BANK)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .acc(acc), .bank(bank),
      .reg_sel(reg_sel), .ext_cs_n(ext_cs_n)
   );

   bwd_readback #(.BANK_BITS(BANK_BITS), .SIGNATURE(SIGNATURE)) u_rb (
      .clk(clk), .rst_n(rst_n), .acc(acc), .bank(bank), .rdata(rdata)
   );

   // R10: unused bank numbers decode to nothing
   assert_gap_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(bank) >= INT_BANKS && 32'(bank) != EXT_BANK) |-> (reg_sel == '0 && ext_cs_n));

   // R8: the external bank never reaches an internal slot
   assert_ext_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(bank) == EXT_BANK) |-> (reg_sel == '0));

endmodule

// File: tb/bank_window_decoder_test.sv
module bank_window_decoder_test;

   localparam int NSEL = 28;
   localparam int NONE = 31;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cyc_valid, rd_stb, wr_stb;
   logic [3:0]  addr, byte_en;
   logic [31:0] wdata, rdata;
   logic [NSEL-1:0] reg_sel;
   logic        ext_cs_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;   // 250 MHz

   bank_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .addr(addr), .byte_en(byte_en), .wdata(wdata), .rdata(rdata),
      .reg_sel(reg_sel), .ext_cs_n(ext_cs_n)
   );

   typedef struct packed {
      logic [2:0]  bank;
      logic        rd;
      logic        wr;
      logic [3:0]  addr;
      logic [3:0]  be;
      logic [4:0]  sel;
      logic        ext_n;
      logic [31:0] rd_exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 1'b1, 1'b0, 4'h0, 4'b0011, 5'd0,  1'b1, 32'h0},
      '{3'd1, 1'b0, 1'b1, 4'h4, 4'b0011, 5'd9,  1'b1, 32'h0},
      '{3'd2, 1'b1, 1'b0, 4'h8, 4'b1100, 5'd19, 1'b1, 32'h0},
      '{3'd3, 1'b1, 1'b0, 4'hC, 4'b0011, 5'd27, 1'b1, 32'h0},
      '{3'd3, 1'b1, 1'b0, 4'hC, 4'b1111, 5'd27, 1'b1, 32'h3303_0000},
      '{3'd7, 1'b1, 1'b0, 4'h0, 4'b0011, 5'd31, 1'b0, 32'h0},
      '{3'd7, 1'b0, 1'b1, 4'h6, 4'b1100, 5'd31, 1'b0, 32'h0},
      '{3'd7, 1'b1, 1'b0, 4'h8, 4'b0011, 5'd31, 1'b1, 32'h0},
      '{3'd5, 1'b1, 1'b0, 4'h2, 4'b0011, 5'd31, 1'b1, 32'h0},
      '{3'd4, 1'b1, 1'b0, 4'hE, 4'b1100, 5'd31, 1'b1, 32'h3304_0000},
      '{3'd0, 1'b1, 1'b0, 4'h6, 4'b1100, 5'd3,  1'b1, 32'h0},
      '{3'd6, 1'b1, 1'b0, 4'hF, 4'b1000, 5'd31, 1'b1, 32'h3300_0000},
      '{3'd1, 1'b1, 1'b0, 4'h8, 4'b1111, 5'd11, 1'b1, 32'h0}
   };

   function automatic logic [NSEL-1:0] sel_of(input int idx);
      return (idx == NONE) ? '0 : (NSEL'(1) << idx);
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      cyc_valid = 0; rd_stb = 0; wr_stb = 0; addr = 0; byte_en = 0; wdata = 0;
   endtask

   // drive at negedge; sample at 1 ns before the next rising edge
   task automatic drive(input logic v, input logic r, input logic w, input logic [3:0] a,
                        input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cyc_valid = v; rd_stb = r; wr_stb = w; addr = a; byte_en = be; wdata = d;
      #1;
   endtask

   task automatic set_bank(input logic [2:0] b);
      drive(1, 0, 1, 4'hE, 4'b0100, {8'h00, 5'b0, b, 16'h0});
      @(negedge clk); idle();
   endtask

   task automatic read_bank(output logic [31:0] v);
      drive(1, 1, 0, 4'hE, 4'b1100, 32'h0);
      v = rdata;
      idle();
   endtask

   logic [31:0] rv;

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      drive(1, 1, 0, 4'hE, 4'b1100, 32'h0);
      check("R1 reset readback", rdata, 32'h3300_0000);
      check("R1 reset no select", 32'(reg_sel), 32'h0);
      idle();

      // table walk: R5 R6 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         set_bank(VEC[i].bank);
         drive(1, VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].be, 32'h0);
         check($sformatf("R6 vec %0d sel", i), 32'(reg_sel), 32'(sel_of(int'(VEC[i].sel))));
         check($sformatf("R8 R9 vec %0d ext_cs_n", i), 32'(ext_cs_n), 32'(VEC[i].ext_n));
         check($sformatf("R5 vec %0d rdata", i), rdata, VEC[i].rd_exp);
         idle();
      end

      // R2 upper bank-byte bits dropped
      drive(1, 0, 1, 4'hE, 4'b0100, 32'h00FD_0000);
      @(negedge clk); idle();
      read_bank(rv);
      check("R2 bank load masks high bits", rv, 32'h3305_0000);

      // R10 writes in a gap bank leave the bank register alone; reads return 0
      drive(1, 0, 1, 4'h0, 4'b1111, 32'hFFFF_FFFF);
      check("R10 gap bank write no select", 32'(reg_sel), 32'h0);
      @(negedge clk); idle();
      drive(1, 1, 0, 4'h4, 4'b1111, 32'h0);
      check("R10 gap bank read zero", rdata, 32'h0);
      idle();
      read_bank(rv);
      check("R10 gap bank write ignored", rv, 32'h3305_0000);

      // R3 write to identity byte ignored; R4 access in bank 5
      drive(1, 0, 1, 4'hF, 4'b1000, 32'hFFFF_FFFF);
      @(negedge clk); idle();
      read_bank(rv);
      check("R3 R4 identity byte write ignored", rv, 32'h3305_0000);

      // R7 doubleword write at Ch in bank 3
      set_bank(3'd3);
      drive(1, 0, 1, 4'hC, 4'b1111, 32'h0002_ABCD);
      check("R7 dword write suppresses slot select", 32'(reg_sel), 32'h0);
      @(negedge clk); idle();
      read_bank(rv);
      check("R7 dword write updates bank", rv, 32'h3302_0000);

      // R7 byte write at Fh in bank 0: no select, bank unchanged
      set_bank(3'd0);
      drive(1, 0, 1, 4'hF, 4'b1000, 32'h0700_0000);
      check("R7 identity byte write no select", 32'(reg_sel), 32'h0);
      @(negedge clk); idle();
      read_bank(rv);
      check("R7 bank unchanged by Fh write", rv, 32'h3300_0000);

      // R11 no valid qualifier
      set_bank(3'd2);
      drive(0, 1, 0, 4'h0, 4'b0011, 32'h0);
      check("R11 no valid no select", 32'(reg_sel), 32'h0);
      drive(0, 1, 0, 4'hE, 4'b1100, 32'h0);
      check("R11 no valid rdata zero", rdata, 32'h0);
      drive(0, 0, 1, 4'hE, 4'b0100, 32'h0007_0000);
      @(negedge clk); idle();
      read_bank(rv);
      check("R11 no valid write ignored", rv, 32'h3302_0000);

      // R9 bank 7 without valid or strobe
      set_bank(3'd7);
      drive(0, 1, 0, 4'h0, 4'b0011, 32'h0);
      check("R9 ext_cs_n needs valid", 32'(ext_cs_n), 32'h1);
      drive(1, 0, 0, 4'h0, 4'b0011, 32'h0);
      check("R9 ext_cs_n needs strobe", 32'(ext_cs_n), 32'h1);
      idle();
      read_bank(rv);
      check("R4 bank readable in bank 7", rv, 32'h3307_0000);

      // R1 reset mid run
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      read_bank(rv);
      check("R1 reset clears bank", rv, 32'h3300_0000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule